// File: doc/BRIEF.md
# Peripheral Interrupt Collector with Keyed Core Reset

This block sits between a register bus and a serial peripheral core. It collects seven single-cycle event pulses from the core into a sticky status register. Each status bit is masked by its own enable bit, and the masked result is gated by one global enable. The block drives a single level-sensitive interrupt line. Software acknowledges events by writing ones into the status register, so writing back the value it has just read clears exactly the events it has seen.

The same register port also holds a reset register. When the key value 0x0000000A is written to it, the block drives a reset pulse of fixed length to the wrapped core. Any other value written there does nothing. This keeps a stray bus write from restarting the peripheral.

Top module: `irq_softrst_wrap`

## Requirements
- R1: After reset the status, enable and global-enable registers read 0, `irq_o` is low and `core_rst_o` is low.
- R2: An event pulse on `events_i[k]` sets status bit k, readable at offset 0x20, from the next clock edge on, even when enable bit k is 0. The bit positions are 0 mode fault, 1 slave-select fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun and 6 transmit half empty.
- R3: A write to offset 0x20 clears each status bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R4: When an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R5: The per-event enable register at offset 0x28 stores data bits 6:0, reads them back, reads bits 31:7 as 0, and changes only when written.
- R6: The global enable at offset 0x1C stores data bit 31 only. All other bits read 0.
- R7: `irq_o` is high exactly when the global enable is 1 and some status bit has its enable bit set. It follows the registers in the same cycle that they change.
- R8: Writing exactly 0x0000000A to offset 0x40 drives `core_rst_o` high for exactly 4 clock cycles, starting after the edge that takes the write.
- R9: Writing any other value to offset 0x40 leaves `core_rst_o` and all registers unchanged. Offset 0x40 reads 0.
- R10: Writes to unmapped offsets are ignored, and those offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| events_i | input | 7 | Event pulses from the peripheral core |
| irq_o | output | 1 | Level-sensitive interrupt request |
| core_rst_o | output | 1 | Active-high reset to the peripheral core |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the very cycle a new event for the same bit arrives. An ordinary read-then-clear flow almost never lines these up. The bench reaches it by driving the event pulse and the status write on the same falling edge, and then reads the bit back. It also restarts a reset pulse and feeds near-miss key values, such as 0x0B and 0x10A. This shows that only the exact word starts the pulse and that the pulse length is counted from the write.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

  // Register byte offsets
  localparam logic [7:0] OFS_GLB_EN   = 8'h1C;
  localparam logic [7:0] OFS_EVT_STAT = 8'h20;
  localparam logic [7:0] OFS_EVT_EN   = 8'h28;
  localparam logic [7:0] OFS_CORE_RST = 8'h40;

  // One-cycle write strobes, one per register
  typedef struct packed {
    logic glb;
    logic stat;
    logic en;
    logic rst;
  } wr_strobe_t;

  // Next value of a sticky status bit: a new event wins over an acknowledge
  function automatic logic sticky_next(logic cur, logic ack, logic evt);
    return (cur & ~ack) | evt;
  endfunction

  // Level of the interrupt line
  function automatic logic irq_level(logic glb, logic [31:0] stat, logic [31:0] en);
    return glb & (|(stat & en));
  endfunction

endpackage

// File: rtl/irqw_decode.sv
module irqw_decode
  import irqw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 7,
  parameter logic [31:0] RST_KEY = 32'h0000_000A
) (
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               glb_q,
  input  logic [NUM_EVT-1:0] stat_q,
  input  logic [NUM_EVT-1:0] en_q,
  output wr_strobe_t         strb,
  output logic               key_hit,
  output logic [DATA_W-1:0]  rdata
);

  localparam logic [ADDR_W-1:0] A_GLB  = ADDR_W'(OFS_GLB_EN);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_EVT_STAT);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EVT_EN);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFS_CORE_RST);

  always_comb begin
    strb.glb  = wr_en && (addr == A_GLB);
    strb.stat = wr_en && (addr == A_STAT);
    strb.en   = wr_en && (addr == A_EN);
    strb.rst  = wr_en && (addr == A_RST);
  end

  assign key_hit = strb.rst && (wdata == DATA_W'(RST_KEY));

  always_comb begin
    rdata = '0;
    case (addr)
      A_GLB:   rdata[DATA_W-1]    = glb_q;
      A_STAT:  rdata[NUM_EVT-1:0] = stat_q;
      A_EN:    rdata[NUM_EVT-1:0] = en_q;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/irqw_status.sv
module irqw_status
  import irqw_pkg::*;
#(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_wr,
  input  logic [NUM_EVT-1:0] ack_bits,
  input  logic [NUM_EVT-1:0] events_i,
  output logic [NUM_EVT-1:0] stat_q
);

  logic [NUM_EVT-1:0] ack_eff;
  assign ack_eff = ack_wr ? ack_bits : '0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= sticky_next(stat_q[i], ack_eff[i], events_i[i]);
    end
  end

endmodule

// File: rtl/irqw_ctrl_regs.sv
module irqw_ctrl_regs #(
  parameter int NUM_EVT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_wr,
  input  logic               glb_bit,
  input  logic               en_wr,
  input  logic [NUM_EVT-1:0] en_bits,
  output logic               glb_q,
  output logic [NUM_EVT-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b0;
      en_q  <= '0;
    end else begin
      if (glb_wr) glb_q <= glb_bit;
      if (en_wr)  en_q  <= en_bits;
    end
  end

endmodule

// File: rtl/irqw_rst_pulse.sv
module irqw_rst_pulse #(
  parameter int RST_LEN = 4,
  localparam int CW = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse_o
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire)           left_q <= CW'(RST_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse_o = (left_q != '0);

endmodule

// File: rtl/irq_softrst_wrap.sv
module irq_softrst_wrap
  import irqw_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 7,
  parameter int RST_LEN = 4,
  parameter logic [31:0] RST_KEY = 32'h0000_000A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] events_i,
  output logic               irq_o,
  output logic               core_rst_o
);

  wr_strobe_t         strb;
  logic               key_hit;
  logic               glb_q;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] en_q;

  // Named internal events for the checker
  logic wr_stat_s, wr_en_s, wr_rst_s;
  assign wr_stat_s = strb.stat;
  assign wr_en_s   = strb.en;
  assign wr_rst_s  = strb.rst;

  irqw_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .RST_KEY(RST_KEY)
  ) u_decode (
    .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .glb_q(glb_q), .stat_q(stat_q), .en_q(en_q),
    .strb(strb), .key_hit(key_hit), .rdata(reg_rdata)
  );

  irqw_status #(.NUM_EVT(NUM_EVT)) u_status (
    .clk(clk), .rst_n(rst_n),
    .ack_wr(strb.stat), .ack_bits(reg_wdata[NUM_EVT-1:0]),
    .events_i(events_i), .stat_q(stat_q)
  );

  irqw_ctrl_regs #(.NUM_EVT(NUM_EVT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .glb_wr(strb.glb), .glb_bit(reg_wdata[DATA_W-1]),
    .en_wr(strb.en), .en_bits(reg_wdata[NUM_EVT-1:0]),
    .glb_q(glb_q), .en_q(en_q)
  );

  irqw_rst_pulse #(.RST_LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_n(rst_n), .fire(key_hit), .pulse_o(core_rst_o)
  );

  assign irq_o = irq_level(glb_q, 32'(stat_q), 32'(en_q));

endmodule

// File: rtl/irqw_chk.sv
module irqw_chk #(
  parameter int DATA_W  = 32,
  parameter int NUM_EVT = 7,
  parameter int RST_LEN = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] events_i,
  input logic [DATA_W-1:0]  wdata,
  input logic               wr_stat,
  input logic               wr_en,
  input logic               wr_rst,
  input logic               key_hit,
  input logic               glb_q,
  input logic [NUM_EVT-1:0] stat_q,
  input logic [NUM_EVT-1:0] en_q,
  input logic               irq_o,
  input logic               core_rst_o
);

  localparam int RW = $clog2(RST_LEN + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (key_hit)    run_q <= '0;
    else if (core_rst_o) run_q <= run_q + 1'b1;
  end

  // R2 R4
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|events_i) |=> ((stat_q & $past(events_i)) == $past(events_i)));

  // R3
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && (events_i == '0)) |=> ((stat_q & $past(wdata[NUM_EVT-1:0])) == '0));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> glb_q);

  // R8
  key_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> core_rst_o);

  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_o) |-> $past(key_hit));

  // R8
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (run_q == RW'(RST_LEN)));

  // R9
  nokey_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && !key_hit && !core_rst_o) |=> !core_rst_o);

endmodule

bind irq_softrst_wrap irqw_chk #(
  .DATA_W(DATA_W), .NUM_EVT(NUM_EVT), .RST_LEN(RST_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .events_i(events_i), .wdata(reg_wdata),
  .wr_stat(wr_stat_s), .wr_en(wr_en_s), .wr_rst(wr_rst_s),
  .key_hit(key_hit), .glb_q(glb_q), .stat_q(stat_q), .en_q(en_q),
  .irq_o(irq_o), .core_rst_o(core_rst_o)
);

// File: tb/irq_softrst_wrap_tb.sv
`timescale 1ns/100ps
module irq_softrst_wrap_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  events_i = '0;
  logic        irq_o;
  logic        core_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_softrst_wrap u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events_i(events_i),
    .irq_o(irq_o), .core_rst_o(core_rst_o)
  );

  // kind: 0 read data, 1 irq line, 2 core reset line
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: 1 ns after each rising edge, compare everything queued
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = reg_rdata;
        1:       act = {31'b0, irq_o};
        default: act = {31'b0, core_rst_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    reg_addr = a;
    push(0, exp, tag);
    @(negedge clk);
  endtask

  task automatic line(int kind, logic exp, string tag);
    push(kind, {31'b0, exp}, tag);
    @(negedge clk);
  endtask

  task automatic pulse(logic [6:0] m);
    events_i = m;
    @(negedge clk);
    events_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h20, 32'h0, "R1 status after reset");
    rd(8'h28, 32'h0, "R1 enable after reset");
    rd(8'h1C, 32'h0, "R1 global enable after reset");
    line(1, 1'b0, "R1 irq after reset");
    line(2, 1'b0, "R1 core reset after reset");

    // R2 latching with enable 0 (bit 2 transmit empty)
    pulse(7'h04);
    rd(8'h20, 32'h04, "R2 event latched while disabled");
    line(1, 1'b0, "R7 no irq with enable 0");

    // R5 / R6 readback masks
    wr(8'h28, 32'hFFFF_FF04);
    rd(8'h28, 32'h04, "R5 enable readback masked");
    line(1, 1'b0, "R7 no irq without global enable");
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h8000_0000, "R6 global enable bit 31 only");
    line(1, 1'b1, "R7 irq with all enables");

    // R3 write back the value read clears it
    wr(8'h20, 32'h04);
    rd(8'h20, 32'h0, "R3 write-back acknowledges");
    line(1, 1'b0, "R7 irq drops after acknowledge");

    // R2 several positions, R3 partial clear
    pulse(7'h55);
    rd(8'h20, 32'h55, "R2 multiple events");
    line(1, 1'b1, "R7 irq from bit 2 again");
    wr(8'h20, 32'h05);
    rd(8'h20, 32'h50, "R3 partial clear keeps zeros");
    line(1, 1'b0, "R7 no irq from masked bits");
    wr(8'h28, 32'h40);
    line(1, 1'b1, "R7 irq from bit 6 once enabled");
    wr(8'h1C, 32'h7FFF_FFFF);
    line(1, 1'b0, "R7 global disable gates irq");
    wr(8'h20, 32'h50);
    rd(8'h20, 32'h0, "R3 clear rest");

    // R4 event and clear in the same cycle
    pulse(7'h02);
    events_i = 7'h02; reg_wr_en = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h02;
    @(negedge clk);
    events_i = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    rd(8'h20, 32'h02, "R4 event beats same-cycle clear");

    // R8 key write gives exactly 4 cycles
    reg_wr_en = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h0A;
    push(2, 32'h1, "R8 reset cycle 1");
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
    line(2, 1'b1, "R8 reset cycle 2");
    line(2, 1'b1, "R8 reset cycle 3");
    line(2, 1'b1, "R8 reset cycle 4");
    line(2, 1'b0, "R8 reset ends after 4");

    // R8 retrigger mid-pulse restarts the count
    wr(8'h40, 32'h0A);
    line(2, 1'b1, "R8 pulse running");
    wr(8'h40, 32'h0A);
    line(2, 1'b1, "R8 restarted 2");
    line(2, 1'b1, "R8 restarted 3");
    line(2, 1'b1, "R8 restarted 4");
    line(2, 1'b0, "R8 restarted pulse ends");

    // R9 near-miss keys do nothing
    wr(8'h40, 32'h0B);
    line(2, 1'b0, "R9 value 0x0B ignored");
    wr(8'h40, 32'h10A);
    line(2, 1'b0, "R9 value 0x10A ignored");
    rd(8'h40, 32'h0, "R9 reset register reads 0");
    rd(8'h20, 32'h02, "R9 status untouched");
    rd(8'h28, 32'h40, "R9 enable untouched");

    // R10 unmapped offset
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, 32'h0, "R10 unmapped reads 0");
    rd(8'h28, 32'h40, "R10 enable untouched");
    rd(8'h1C, 32'h0, "R10 global enable untouched");
    rd(8'h20, 32'h02, "R10 status untouched");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule